// File: doc/BRIEF.md
# Exception Escalation and Double-Fault Controller

This block decides what happens to each exception a processor core raises before the core starts delivering it. Each event carries a vector number and a raw error code. The controller puts the vector into one of four severity classes: benign, contributory, page-fault class or double fault. It compares that class with the class of the exception already being delivered. From that comparison it chooses one of three outcomes:

- deliver the event as requested;
- escalate it to a double fault (vector 8);
- request a shutdown, because the event is a triple fault.

For every delivery the controller also gives the core the following:

- whether an error code is pushed, and the corrected error code;
- whether the instruction pointer and the speculative stack pointer roll back;
- whether the resume flag is set;
- for debug exceptions, the merged debug-status word and the cleaned debug-control word.

The core pulses a completion input when the handler entry is done. That pulse returns the tracked class to benign and clears the internal external-event flag. Gate lookup and the stack pushes happen outside this block.

Top module: `exc_escalate_ctrl`

## Requirements
- R1: Vectors 0, 10, 11, 12, 13 and 21 are contributory. Vectors 14 and 20 are page-fault class. Vector 8 is the double-fault class. Every other vector below 32 is benign.
- R2: The requested event is replaced by a delivery of vector 8 in two cases: a contributory event arrives while the tracked class is contributory, or a contributory or page-fault-class event arrives while the tracked class is page-fault class. The replacement delivery has error code 0 and pushes that code unless in real mode. Every other pairing delivers the requested vector unchanged.
- R3: A fault-kind event (any vector except 3, 4 and 18) that arrives while the tracked class is double fault produces out_shutdown and no delivery. The tracked class stays at double fault.
- R4: Vectors 3 and 4 are traps, vector 18 is an abort, and the rest are faults. A delivered fault asserts out_rollback_ip. It asserts out_rollback_sp when spec_sp was high with the event. It asserts out_set_rf unless the delivered vector is 1. Traps and aborts assert none of these three.
- R5: out_push_err is high only for delivered vectors 8, 10, 11, 12, 13, 14, 17 and 21, and only outside real mode. When no error code is pushed, including every real-mode event, out_errcode is 0.
- R6: For a pushed error code on any vector other than 8, 14 and 21, bit 0 is replaced by the internal external-event flag. For vectors 14 and 21 the raw code passes through unchanged.
- R7: An accepted event records its delivered class as the tracked class and sets the external-event flag, except that a shutdown leaves the tracked class unchanged. A dlv_done pulse with no event in the same cycle returns the tracked class to benign and clears the flag. When both occur in the same cycle, the event wins.
- R8: When vector 1 is delivered, out_dbg_wr is high and out_dr6 = (dr6_cur & 0xFFFF6FF0) | (dr6_hit & 0x0000E00F). out_dr7 equals dr7_cur with bit 13 (the general-detect enable) cleared. At all other times these three outputs are 0.
- R9: An event whose vector is 32 or above produces out_bad_vec and no delivery. It changes neither the tracked class nor the external-event flag.
- R10: Every output is registered and reflects the event sampled at the previous rising clock edge. Each output is a single-cycle pulse. At most one of out_valid, out_shutdown and out_bad_vec is high at a time. All outputs are 0 in a cycle that follows no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_valid | input | 1 | An exception event is presented this cycle |
| evt_vector | input | VEC_W | Requested vector |
| evt_errcode | input | ERR_W | Raw error code |
| real_mode | input | 1 | Core is in real-address mode |
| spec_sp | input | 1 | Speculative stack pointer must be restored if the event is a fault |
| dlv_done | input | 1 | Handler entry is complete |
| dr6_cur | input | DBG_W | Current debug-status word |
| dr6_hit | input | DBG_W | Pending debug-status bits |
| dr7_cur | input | DBG_W | Current debug-control word |
| out_valid | output | 1 | Deliver the vector in out_vector |
| out_vector | output | XW | Vector to deliver |
| out_errcode | output | ERR_W | Corrected error code |
| out_push_err | output | 1 | Push the error code |
| out_rollback_ip | output | 1 | Restore the instruction pointer |
| out_rollback_sp | output | 1 | Restore the speculative stack pointer |
| out_set_rf | output | 1 | Set the resume flag |
| out_shutdown | output | 1 | Triple fault: shutdown request |
| out_bad_vec | output | 1 | Event vector out of range, dropped |
| out_dbg_wr | output | 1 | Write the debug words back |
| out_dr6 | output | DBG_W | Merged debug-status word |
| out_dr7 | output | DBG_W | Debug-control word with general-detect cleared |

## Verification
The hardest case to reach is a triple fault. It needs two earlier events that were both accepted without a completion pulse between them, and the first must leave a class that the second escalates. The bench sweeps every ordered pair of vectors 0 to 31, with a completion pulse before each pair. When the model shows that a pair left the tracked class at double fault, the bench sends a third, fault-kind event to provoke the shutdown. The first event of each pair carries error-code bit 0 set while the flag is clear, and the second carries it clear while the flag is set, so the bit-0 replacement is seen in both directions.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

  typedef enum logic [1:0] {
    XC_BENIGN  = 2'd0,
    XC_CONTRIB = 2'd1,
    XC_PAGE    = 2'd2,
    XC_DOUBLE  = 2'd3
  } xc_class_e;

  typedef enum logic [1:0] {
    XK_FAULT = 2'd0,
    XK_TRAP  = 2'd1,
    XK_ABORT = 2'd2
  } xk_kind_e;

  typedef struct packed {
    xc_class_e cls;
    xk_kind_e  kind;
    logic      has_err;
    logic      keep_bit0;
  } xc_info_t;

  localparam int unsigned DF_VEC = 8;
  localparam int unsigned DB_VEC = 1;

  localparam xc_info_t DF_INFO = '{cls: XC_DOUBLE, kind: XK_FAULT,
                                   has_err: 1'b1, keep_bit0: 1'b1};

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_esc_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NUM_EXC = 32
) (
  input  logic [VEC_W-1:0] vec,
  output logic             in_range,
  output xc_info_t         info
);

  logic [31:0] v_i;

  always_comb begin
    v_i      = 32'(vec);
    in_range = (v_i < 32'(NUM_EXC));

    if (v_i inside {0, 10, 11, 12, 13, 21})
      info.cls = XC_CONTRIB;
    else if (v_i inside {14, 20})
      info.cls = XC_PAGE;
    else if (v_i == DF_VEC)
      info.cls = XC_DOUBLE;
    else
      info.cls = XC_BENIGN;

    if (v_i inside {3, 4})
      info.kind = XK_TRAP;
    else if (v_i == 18)
      info.kind = XK_ABORT;
    else
      info.kind = XK_FAULT;

    info.has_err   = (v_i inside {8, 10, 11, 12, 13, 14, 17, 21});
    info.keep_bit0 = (v_i inside {8, 14, 21});
  end

endmodule

// File: rtl/exc_escalate_matrix.sv
module exc_escalate_matrix
  import exc_esc_pkg::*;
(
  input  xc_class_e trk,
  input  xc_class_e ncls,
  input  xk_kind_e  nkind,
  output logic      go_double,
  output logic      go_shutdown
);

  // Row = tracked class, column = new class, each benign/contributory/page.
  // Bit (row*3 + col) set when the pair escalates.
  localparam logic [8:0] BLOCK_MAP = 9'b000_000_000
    | (9'b1 << (1*3 + 1))   // contributory after contributory
    | (9'b1 << (2*3 + 1))   // contributory after page fault
    | (9'b1 << (2*3 + 2));  // page fault after page fault

  logic [3:0] idx;
  logic       row_ok;
  logic       col_ok;

  always_comb begin
    row_ok      = (trk != XC_DOUBLE);
    col_ok      = (ncls != XC_DOUBLE);
    idx         = 4'(trk) * 4'd3 + 4'(ncls);
    go_shutdown = (trk == XC_DOUBLE) && (nkind == XK_FAULT);
    go_double   = row_ok && col_ok && BLOCK_MAP[idx];
  end

endmodule

// File: rtl/exc_dbg_merge.sv
module exc_dbg_merge #(
  parameter int          DBG_W     = 32,
  parameter logic [31:0] KEEP_MASK = 32'hFFFF_6FF0,
  parameter logic [31:0] TAKE_MASK = 32'h0000_E00F,
  parameter int          GD_BIT    = 13
) (
  input  logic [DBG_W-1:0] stat_old,
  input  logic [DBG_W-1:0] stat_hit,
  input  logic [DBG_W-1:0] ctl_old,
  output logic [DBG_W-1:0] stat_new,
  output logic [DBG_W-1:0] ctl_new
);

  localparam logic [DBG_W-1:0] KEEP = KEEP_MASK[DBG_W-1:0];
  localparam logic [DBG_W-1:0] TAKE = TAKE_MASK[DBG_W-1:0];

  always_comb begin
    stat_new         = (stat_old & KEEP) | (stat_hit & TAKE);
    ctl_new          = ctl_old;
    ctl_new[GD_BIT]  = 1'b0;
  end

endmodule

// File: rtl/exc_escalate_ctrl.sv
module exc_escalate_ctrl
  import exc_esc_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ERR_W   = 16,
  parameter int DBG_W   = 32,
  parameter int NUM_EXC = 32,
  localparam int XW     = $clog2(NUM_EXC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [VEC_W-1:0] evt_vector,
  input  logic [ERR_W-1:0] evt_errcode,
  input  logic             real_mode,
  input  logic             spec_sp,
  input  logic             dlv_done,
  input  logic [DBG_W-1:0] dr6_cur,
  input  logic [DBG_W-1:0] dr6_hit,
  input  logic [DBG_W-1:0] dr7_cur,
  output logic             out_valid,
  output logic [XW-1:0]    out_vector,
  output logic [ERR_W-1:0] out_errcode,
  output logic             out_push_err,
  output logic             out_rollback_ip,
  output logic             out_rollback_sp,
  output logic             out_set_rf,
  output logic             out_shutdown,
  output logic             out_bad_vec,
  output logic             out_dbg_wr,
  output logic [DBG_W-1:0] out_dr6,
  output logic [DBG_W-1:0] out_dr7
);

  // ---------------- reset synchronizer ----------------
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // ---------------- state ----------------
  xc_class_e trk_q, trk_d;
  logic      ext_q, ext_d;
  logic      st_en;

  // ---------------- classification ----------------
  logic     in_range;
  xc_info_t req_info;

  exc_classify #(.VEC_W(VEC_W), .NUM_EXC(NUM_EXC)) u_cls (
    .vec      (evt_vector),
    .in_range (in_range),
    .info     (req_info)
  );

  logic esc_double, esc_shutdown;

  exc_escalate_matrix u_mtx (
    .trk         (trk_q),
    .ncls        (req_info.cls),
    .nkind       (req_info.kind),
    .go_double   (esc_double),
    .go_shutdown (esc_shutdown)
  );

  logic [DBG_W-1:0] dr6_m, dr7_m;

  exc_dbg_merge #(.DBG_W(DBG_W)) u_dbg (
    .stat_old (dr6_cur),
    .stat_hit (dr6_hit),
    .ctl_old  (dr7_cur),
    .stat_new (dr6_m),
    .ctl_new  (dr7_m)
  );

  // ---------------- decision ----------------
  logic             acc, bad, shut, dbl, dlv;
  xc_info_t         fin_info;
  logic [XW-1:0]    fin_vec;
  logic             push, rb_ip, is_db;
  logic [ERR_W-1:0] fin_err;

  always_comb begin
    acc      = evt_valid && in_range;
    bad      = evt_valid && !in_range;
    shut     = acc && esc_shutdown;
    dbl      = acc && !esc_shutdown && esc_double;
    dlv      = acc && !esc_shutdown;
    fin_info = dbl ? DF_INFO : req_info;
    fin_vec  = dbl ? XW'(DF_VEC) : evt_vector[XW-1:0];
    push     = dlv && fin_info.has_err && !real_mode;
    if (!push || dbl)
      fin_err = '0;
    else if (fin_info.keep_bit0)
      fin_err = evt_errcode;
    else
      fin_err = {evt_errcode[ERR_W-1:1], ext_q};
    rb_ip    = dlv && (fin_info.kind == XK_FAULT);
    is_db    = dlv && (32'(fin_vec) == DB_VEC);
  end

  // ---------------- next state ----------------
  always_comb begin
    st_en = acc || dlv_done;
    trk_d = trk_q;
    ext_d = ext_q;
    if (acc) begin
      ext_d = 1'b1;
      if (!shut) trk_d = fin_info.cls;
    end else if (dlv_done) begin
      ext_d = 1'b0;
      trk_d = XC_BENIGN;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trk_q <= XC_BENIGN;
      ext_q <= 1'b0;
    end else if (st_en) begin
      trk_q <= trk_d;
      ext_q <= ext_d;
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid       <= 1'b0;
      out_vector      <= '0;
      out_errcode     <= '0;
      out_push_err    <= 1'b0;
      out_rollback_ip <= 1'b0;
      out_rollback_sp <= 1'b0;
      out_set_rf      <= 1'b0;
      out_shutdown    <= 1'b0;
      out_bad_vec     <= 1'b0;
      out_dbg_wr      <= 1'b0;
      out_dr6         <= '0;
      out_dr7         <= '0;
    end else begin
      out_valid       <= dlv;
      out_vector      <= dlv ? fin_vec : '0;
      out_errcode     <= fin_err;
      out_push_err    <= push;
      out_rollback_ip <= rb_ip;
      out_rollback_sp <= rb_ip && spec_sp;
      out_set_rf      <= rb_ip && (32'(fin_vec) != DB_VEC);
      out_shutdown    <= shut;
      out_bad_vec     <= bad;
      out_dbg_wr      <= is_db;
      out_dr6         <= is_db ? dr6_m : '0;
      out_dr7         <= is_db ? dr7_m : '0;
    end
  end

endmodule

// File: rtl/exc_escalate_chk.sv
module exc_escalate_chk
  import exc_esc_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NUM_EXC = 32,
  parameter int ERR_W   = 16,
  localparam int XW     = $clog2(NUM_EXC)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             evt_valid,
  input logic [VEC_W-1:0] evt_vector,
  input logic             real_mode,
  input logic             dlv_done,
  input xc_class_e        trk_q,
  input logic             out_valid,
  input logic [XW-1:0]    out_vector,
  input logic [ERR_W-1:0] out_errcode,
  input logic             out_push_err,
  input logic             out_rollback_ip,
  input logic             out_rollback_sp,
  input logic             out_set_rf,
  input logic             out_shutdown,
  input logic             out_bad_vec
);

  logic in_rng, is_contrib, is_fault;
  always_comb begin
    in_rng     = 32'(evt_vector) < 32'(NUM_EXC);
    is_contrib = evt_vector inside {0, 10, 11, 12, 13, 21};
    is_fault   = in_rng && !(evt_vector inside {3, 4, 18});
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({out_valid, out_shutdown, out_bad_vec}));  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !evt_valid |=> !out_valid && !out_shutdown && !out_bad_vec);  // R10

  AST_BAD_VECTOR: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_valid && !in_rng |=> out_bad_vec && !out_valid);  // R9

  AST_DOUBLE_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_valid && is_fault && trk_q == XC_DOUBLE |=> out_shutdown);  // R3

  AST_CONTRIB_PAIR: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_valid && is_contrib && trk_q == XC_CONTRIB |=>
      out_valid && out_vector == XW'(8));  // R2

  AST_REAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_ok)
    evt_valid && real_mode |=> !out_push_err && out_errcode == '0);  // R5

  AST_DB_NO_RF: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && out_vector == XW'(1) |-> !out_set_rf);  // R4

  AST_SP_WITH_IP: assert property (@(posedge clk) disable iff (!rst_ok)
    out_rollback_sp |-> out_rollback_ip);  // R4

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    dlv_done && !evt_valid |=> trk_q == XC_BENIGN);  // R7

endmodule

bind exc_escalate_ctrl exc_escalate_chk #(
  .VEC_W(VEC_W), .NUM_EXC(NUM_EXC), .ERR_W(ERR_W)
) u_chk (
  .clk             (clk),
  .rst_ok          (rst_sync_n),
  .evt_valid       (evt_valid),
  .evt_vector      (evt_vector),
  .real_mode       (real_mode),
  .dlv_done        (dlv_done),
  .trk_q           (trk_q),
  .out_valid       (out_valid),
  .out_vector      (out_vector),
  .out_errcode     (out_errcode),
  .out_push_err    (out_push_err),
  .out_rollback_ip (out_rollback_ip),
  .out_rollback_sp (out_rollback_sp),
  .out_set_rf      (out_set_rf),
  .out_shutdown    (out_shutdown),
  .out_bad_vec     (out_bad_vec)
);

// File: tb/sim_exc_escalate_ctrl.sv
module sim_exc_escalate_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_vector = '0;
  logic [15:0] evt_errcode = '0;
  logic        real_mode = 1'b0;
  logic        spec_sp = 1'b0;
  logic        dlv_done = 1'b0;
  logic [31:0] dr6_cur = '0, dr6_hit = '0, dr7_cur = '0;
  logic        out_valid;
  logic [4:0]  out_vector;
  logic [15:0] out_errcode;
  logic        out_push_err, out_rollback_ip, out_rollback_sp, out_set_rf;
  logic        out_shutdown, out_bad_vec, out_dbg_wr;
  logic [31:0] out_dr6, out_dr7;

  always #5 clk = ~clk;

  exc_escalate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_vector(evt_vector),
    .evt_errcode(evt_errcode), .real_mode(real_mode), .spec_sp(spec_sp),
    .dlv_done(dlv_done), .dr6_cur(dr6_cur), .dr6_hit(dr6_hit), .dr7_cur(dr7_cur),
    .out_valid(out_valid), .out_vector(out_vector), .out_errcode(out_errcode),
    .out_push_err(out_push_err), .out_rollback_ip(out_rollback_ip),
    .out_rollback_sp(out_rollback_sp), .out_set_rf(out_set_rf),
    .out_shutdown(out_shutdown), .out_bad_vec(out_bad_vec),
    .out_dbg_wr(out_dbg_wr), .out_dr6(out_dr6), .out_dr7(out_dr7)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int m_trk = 0;   // 0 benign, 1 contributory, 2 page, 3 double
  bit m_ext = 1'b0;

  function automatic int b_cls(int v);
    if (v inside {0, 10, 11, 12, 13, 21}) return 1;
    if (v inside {14, 20}) return 2;
    if (v == 8) return 3;
    return 0;
  endfunction

  function automatic int b_kind(int v);   // 0 fault, 1 trap, 2 abort
    if (v inside {3, 4}) return 1;
    if (v == 18) return 2;
    return 0;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic ev(int v, logic [15:0] e, bit rm, bit sp);
    bit shut, dbl, valid, push, rb, isdb;
    int c, fv;
    logic [15:0] ecode;
    logic [31:0] d6, h6, d7;
    d6 = 32'hA5C3_9E17 ^ (v * 32'h0101_0101);
    h6 = 32'h5A3C_61E8 ^ {16'(v), 16'(e)};
    d7 = 32'h0000_2400 | 32'(v);
    evt_valid = 1'b1; evt_vector = 8'(v); evt_errcode = e;
    real_mode = rm; spec_sp = sp;
    dr6_cur = d6; dr6_hit = h6; dr7_cur = d7;
    @(negedge clk);
    if (v >= 32) begin
      cmp("R9", "bad_vec", 32'(out_bad_vec), 1);
      cmp("R9", "valid", 32'(out_valid), 0);
      cmp("R9", "shutdown", 32'(out_shutdown), 0);
    end else begin
      c     = b_cls(v);
      shut  = (m_trk == 3) && (b_kind(v) == 0);
      dbl   = !shut && ((m_trk == 1 && c == 1) || (m_trk == 2 && (c == 1 || c == 2)));
      valid = !shut;
      fv    = dbl ? 8 : v;
      push  = valid && !rm && (fv inside {8, 10, 11, 12, 13, 14, 17, 21});
      if (!push || dbl) ecode = 16'h0;
      else if (fv inside {8, 14, 21}) ecode = e;
      else ecode = {e[15:1], m_ext};
      rb    = valid && b_kind(fv) == 0;
      isdb  = valid && fv == 1;
      cmp("R3", "shutdown", 32'(out_shutdown), 32'(shut));
      cmp("R10", "valid", 32'(out_valid), 32'(valid));
      cmp("R1/R2", "vector", 32'(out_vector), valid ? 32'(fv) : 0);
      cmp("R5", "push_err", 32'(out_push_err), 32'(push));
      cmp("R6", "errcode", 32'(out_errcode), 32'(ecode));
      cmp("R4", "rollback_ip", 32'(out_rollback_ip), 32'(rb));
      cmp("R4", "rollback_sp", 32'(out_rollback_sp), 32'(rb && sp));
      cmp("R4", "set_rf", 32'(out_set_rf), 32'(rb && fv != 1));
      cmp("R9", "bad_vec", 32'(out_bad_vec), 0);
      cmp("R8", "dbg_wr", 32'(out_dbg_wr), 32'(isdb));
      cmp("R8", "dr6", out_dr6, isdb ? ((d6 & 32'hFFFF_6FF0) | (h6 & 32'h0000_E00F)) : 0);
      cmp("R8", "dr7", out_dr7, isdb ? (d7 & ~32'h0000_2000) : 0);
      // R7: model update
      m_ext = 1'b1;
      if (!shut) m_trk = dbl ? 3 : c;
    end
    evt_valid = 1'b0;
  endtask

  task automatic done_pulse();
    dlv_done = 1'b1;
    @(negedge clk);
    dlv_done = 1'b0;
    // R10: cycle after a non-event is quiet
    cmp("R10", "idle valid", 32'(out_valid), 0);
    cmp("R10", "idle shutdown", 32'(out_shutdown), 0);
    cmp("R10", "idle errcode", 32'(out_errcode), 0);
    m_trk = 0; m_ext = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", "reset valid", 32'(out_valid), 0);
    cmp("R10", "reset shutdown", 32'(out_shutdown), 0);
    cmp("R8", "reset dbg_wr", 32'(out_dbg_wr), 0);

    // R1, R2, R3, R4, R6, R7, R8: every ordered pair
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        done_pulse();
        ev(a, 16'(a * 16'h0931) | 16'h0001, 1'b0, (a % 3) == 0);
        ev(b, 16'(b * 16'h1357) & 16'hFFFE, 1'b0, (b % 2) == 0);
        if (m_trk == 3) begin
          ev(13, 16'h00F0, 1'b0, 1'b1);      // R3: fault while double pending
          ev(3, 16'h0000, 1'b0, 1'b0);       // trap still delivered
        end
      end
    end

    // R5: real mode sweep
    for (int v = 0; v < 32; v++) begin
      done_pulse();
      ev(v, 16'hBEEF, 1'b1, 1'b1);
    end

    // R9: out-of-range vectors leave the state alone
    done_pulse();
    ev(14, 16'h0005, 1'b0, 1'b0);
    ev(32, 16'h1234, 1'b0, 1'b0);
    ev(200, 16'h1234, 1'b0, 1'b0);
    ev(255, 16'h1234, 1'b0, 1'b0);
    ev(14, 16'h0006, 1'b0, 1'b0);            // still page after page -> double

    // R7: event in the same cycle as dlv_done wins
    done_pulse();
    ev(13, 16'h0000, 1'b0, 1'b0);
    dlv_done = 1'b1;
    ev(0, 16'h0000, 1'b0, 1'b0);             // contributory after contributory
    dlv_done = 1'b0;
    ev(11, 16'h0010, 1'b0, 1'b0);            // double pending -> shutdown

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule